// File: doc/BRIEF.md
# Byte EEPROM Bridge

This block lets a host that thinks in bytes read and write a serial EEPROM that is organised as 16-bit words. The host hands over one request at a time: a direction, a starting byte offset, a byte count and a key. The bridge talks to a word-level master. That master takes one word command at a time, either a read or a write, and answers each command with a response pulse. The bridge never handles the serial wire itself.

Every request that actually needs the device begins with a probe. The probe reads word 0 with 8-bit addressing. Its result picks one of two address widths for the rest of that request. The bridge then walks the byte range one word at a time. The even byte of each word is the low half and the odd byte is the high half. Read bytes leave on a valid/ready stream and write bytes arrive on another. When a write covers only half of a word, the bridge reads that word first so the other half is kept. A write is carried out only when the request carries the right key.

Each request ends with a one-cycle done pulse. An error flag and a key echo are presented alongside that pulse.

Top module: `eeprom_byte_bridge`

## Requirements
- R1: After a request is accepted that is neither refused nor empty, the first word command is a read (wm_cmd_write=0) of address 0 with wm_cmd_wide=1.
- R2: If the probe returns 16'h8129, every later command in that request has wm_cmd_wide=1 and wm_cmd_addr equal to the byte offset shifted right by one. Any other probe value gives wm_cmd_wide=0, and the address is the low 6 bits of that word index with bits 7:6 zero.
- R3: On a read, each word touched is read exactly once. A word covered in full is sent low byte (bits 7:0) first, then high byte (bits 15:8). When the start offset is odd, only the high byte of the first word is sent. A single last byte at an even offset sends only the low byte.
- R4: On a write with an odd start offset, the bridge reads the first word and then writes {new byte, old bits 7:0} to it.
- R5: Two host bytes that fill one word, the even offset first, become one write of {second byte, first byte}, with no read before it.
- R6: On a write whose last byte sits at an even offset, the bridge reads that word and writes {old bits 15:8, new byte} to it.
- R7: A write request whose key is not 16'h8139 ends with done and err=1 on the cycle after it is accepted. It issues no word command and takes no byte from the write stream.
- R8: On done, rsp_key is 16'h8139 for a read request and 16'h0000 for a write request. err is 0 for every request that is not refused.
- R9: A request with length 0 ends with done and err=0 on the cycle after it is accepted, and it issues no word command.
- R10: req_ready is high only while no request is in progress. A request offered while busy is not accepted and has no effect on the running one.
- R11: Once wm_cmd_valid is raised, the command and all its fields stay unchanged until wm_cmd_ready accepts it.
- R12: During and after reset, req_ready=1, done=0, rd_valid=0, wr_ready=0 and wm_cmd_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Bridge is idle and will take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 9 | Starting byte offset |
| req_len | input | 10 | Number of bytes |
| req_key | input | 16 | Key that must be correct for a write |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Bridge takes a write byte |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte offered |
| rd_ready | input | 1 | Host takes a read byte |
| rd_data | output | 8 | Read byte |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request refused; valid with done |
| rsp_key | output | 16 | Key echo; valid with done |
| wm_cmd_valid | output | 1 | Word command offered |
| wm_cmd_ready | input | 1 | Word master takes the command |
| wm_cmd_write | output | 1 | Command is a word write |
| wm_cmd_wide | output | 1 | 1 = 8-bit addressing, 0 = 6-bit |
| wm_cmd_addr | output | 8 | Word address |
| wm_cmd_wdata | output | 16 | Word to write |
| wm_rsp_valid | input | 1 | Word master finished the command |
| wm_rsp_rdata | input | 16 | Word read, valid with wm_rsp_valid |

## Verification
For refused and empty requests, done and err are due on the cycle right after the accepting edge. For every other request, the result is a sequence of word commands, stream bytes and a final done. None of these happens at a fixed cycle, because the model master stalls wm_cmd_ready and rd_ready in repeating patterns. The bench therefore looks at each handshake halfway between clock edges, when the values that the next edge will transfer are already stable. It compares each transfer against the next entry of a queue filled in advance from the requirements. After done it checks the final word memory, that both queues are empty, and the done-side flags.

// File: rtl/ebb_pkg.sv
package ebb_pkg;

  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROBE,
    ST_STEP,
    ST_FETCH,
    ST_EMIT,
    ST_GATHER,
    ST_STORE
  } seq_state_t;

  // word address seen by the device for a given word index
  function automatic logic [ADDR_W-1:0] dev_word_addr(input logic [ADDR_W-1:0] idx,
                                                      input logic wide,
                                                      input int narrow_bits);
    logic [ADDR_W-1:0] mask;
    mask = ADDR_W'((1 << narrow_bits) - 1);
    return wide ? idx : (idx & mask);
  endfunction

  // byte lane of a word: hi selects bits 15:8
  function automatic logic [BYTE_W-1:0] lane_pick(input logic [WORD_W-1:0] w,
                                                  input logic hi);
    return hi ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0];
  endfunction

  // replace one lane of a word, keep the other
  function automatic logic [WORD_W-1:0] lane_merge(input logic [WORD_W-1:0] w,
                                                   input logic [BYTE_W-1:0] b,
                                                   input logic hi);
    return hi ? {b, w[BYTE_W-1:0]} : {w[WORD_W-1:BYTE_W], b};
  endfunction

endpackage

// File: rtl/ebb_gate.sv
module ebb_gate #(
  parameter int          LEN_W      = 10,
  parameter logic [15:0] ACCESS_KEY = 16'h8139
) (
  input  logic             req_write,
  input  logic [LEN_W-1:0] req_len,
  input  logic [15:0]      req_key,
  output logic             refuse,
  output logic             empty
);

  assign refuse = req_write && (req_key != ACCESS_KEY);
  assign empty  = (req_len == '0);

endmodule

// File: rtl/ebb_wordport.sv
module ebb_wordport
  import ebb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              go_write,
  input  logic              go_wide,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic [WORD_W-1:0] go_wdata,
  output logic              wp_done,
  output logic [WORD_W-1:0] wp_rdata,
  output logic              wm_cmd_valid,
  input  logic              wm_cmd_ready,
  output logic              wm_cmd_write,
  output logic              wm_cmd_wide,
  output logic [ADDR_W-1:0] wm_cmd_addr,
  output logic [WORD_W-1:0] wm_cmd_wdata,
  input  logic              wm_rsp_valid,
  input  logic [WORD_W-1:0] wm_rsp_rdata
);

  logic waiting;
  logic cmd_fire;

  assign cmd_fire = wm_cmd_valid && wm_cmd_ready;
  assign wp_done  = waiting && wm_rsp_valid;
  assign wp_rdata = wm_rsp_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wm_cmd_valid <= 1'b0;
      wm_cmd_write <= 1'b0;
      wm_cmd_wide  <= 1'b0;
      wm_cmd_addr  <= '0;
      wm_cmd_wdata <= '0;
      waiting      <= 1'b0;
    end else begin
      if (go) begin
        wm_cmd_valid <= 1'b1;
        wm_cmd_write <= go_write;
        wm_cmd_wide  <= go_wide;
        wm_cmd_addr  <= go_addr;
        wm_cmd_wdata <= go_wdata;
      end else if (cmd_fire) begin
        wm_cmd_valid <= 1'b0;
        waiting      <= 1'b1;
      end
      if (wp_done) waiting <= 1'b0;
    end
  end

  // R11: a pending command holds still until taken
  assert_cmd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wm_cmd_valid && !wm_cmd_ready) |=> (wm_cmd_valid && $stable(wm_cmd_addr) &&
      $stable(wm_cmd_wdata) && $stable(wm_cmd_write) && $stable(wm_cmd_wide)));

  // R11: the sequencer only starts a command when the port is free
  assert_single_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (!wm_cmd_valid && !waiting));

endmodule

// File: rtl/ebb_seq.sv
module ebb_seq
  import ebb_pkg::*;
#(
  parameter int          LEN_W      = 10,
  parameter int          OFF_W      = 9,
  parameter int          NARROW_AW  = 6,
  parameter logic [15:0] ACCESS_KEY = 16'h8139,
  parameter logic [15:0] BIG_SIG    = 16'h8129
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_fire,
  input  logic              req_write,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              refuse,
  input  logic              empty,
  output logic              busy,
  input  logic              wr_valid,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              wr_ready,
  output logic              rd_valid,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              rd_ready,
  output logic              done,
  output logic              err,
  output logic [15:0]       rsp_key,
  output logic              wp_go,
  output logic              wp_write,
  output logic              wp_wide,
  output logic [ADDR_W-1:0] wp_addr,
  output logic [WORD_W-1:0] wp_wdata,
  input  logic              wp_done,
  input  logic [WORD_W-1:0] wp_rdata
);

  seq_state_t        state;
  logic              op_wr;
  logic              big;
  logic [OFF_W-1:0]  cur_off;
  logic [LEN_W-1:0]  remain;
  logic [WORD_W-1:0] wbuf;

  // named events
  logic              cur_odd;
  logic              word_ends;
  logic              emit_fire;
  logic              gather_fire;
  logic [ADDR_W-1:0] cur_addr;
  logic [WORD_W-1:0] merged;

  assign cur_odd     = cur_off[0];
  assign word_ends   = cur_odd || (remain == LEN_W'(1));
  assign cur_addr    = dev_word_addr(cur_off[OFF_W-1:1], big, NARROW_AW);
  assign merged      = lane_merge(wbuf, wr_data, cur_odd);
  assign busy        = (state != ST_IDLE);
  assign rd_valid    = (state == ST_EMIT);
  assign rd_data     = lane_pick(wbuf, cur_odd);
  assign wr_ready    = (state == ST_GATHER);
  assign emit_fire   = rd_valid && rd_ready;
  assign gather_fire = wr_valid && wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      op_wr    <= 1'b0;
      big      <= 1'b0;
      cur_off  <= '0;
      remain   <= '0;
      wbuf     <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
      rsp_key  <= '0;
      wp_go    <= 1'b0;
      wp_write <= 1'b0;
      wp_wide  <= 1'b0;
      wp_addr  <= '0;
      wp_wdata <= '0;
    end else begin
      done  <= 1'b0;
      wp_go <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_fire) begin
            op_wr   <= req_write;
            cur_off <= req_offset;
            remain  <= req_len;
            if (refuse) begin
              done    <= 1'b1;
              err     <= 1'b1;
              rsp_key <= '0;
            end else if (empty) begin
              done    <= 1'b1;
              err     <= 1'b0;
              rsp_key <= req_write ? 16'h0000 : ACCESS_KEY;
            end else begin
              wp_go    <= 1'b1;
              wp_write <= 1'b0;
              wp_wide  <= 1'b1;
              wp_addr  <= '0;
              state    <= ST_PROBE;
            end
          end
        end
        ST_PROBE: begin
          if (wp_done) begin
            big   <= (wp_rdata == BIG_SIG);
            state <= ST_STEP;
          end
        end
        ST_STEP: begin
          if (remain == '0) begin
            done    <= 1'b1;
            err     <= 1'b0;
            rsp_key <= op_wr ? 16'h0000 : ACCESS_KEY;
            state   <= ST_IDLE;
          end else if (!op_wr || word_ends) begin
            wp_go    <= 1'b1;
            wp_write <= 1'b0;
            wp_wide  <= big;
            wp_addr  <= cur_addr;
            state    <= ST_FETCH;
          end else begin
            state <= ST_GATHER;
          end
        end
        ST_FETCH: begin
          if (wp_done) begin
            wbuf  <= wp_rdata;
            state <= op_wr ? ST_GATHER : ST_EMIT;
          end
        end
        ST_EMIT: begin
          if (emit_fire) begin
            cur_off <= cur_off + OFF_W'(1);
            remain  <= remain - LEN_W'(1);
            if (word_ends) state <= ST_STEP;
          end
        end
        ST_GATHER: begin
          if (gather_fire) begin
            wbuf    <= merged;
            cur_off <= cur_off + OFF_W'(1);
            remain  <= remain - LEN_W'(1);
            if (word_ends) begin
              wp_go    <= 1'b1;
              wp_write <= 1'b1;
              wp_wide  <= big;
              wp_addr  <= cur_addr;
              wp_wdata <= merged;
              state    <= ST_STORE;
            end
          end
        end
        ST_STORE: begin
          if (wp_done) state <= ST_STEP;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: wrong key ends the request on the next cycle with an error
  assert_refuse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && refuse) |=> (done && err));

  // R9: empty requests finish at once without error
  assert_empty_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && !refuse && empty) |=> (done && !err));

  // R2: narrow addressing never sets the upper address bits
  assert_narrow_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_go && !wp_wide) |-> ((wp_addr >> NARROW_AW) == '0));

  // R3: an offered read byte is held until taken
  assert_emit_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  // R10: an accepted request keeps the bridge busy or completes it
  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> (busy || done));

endmodule

// File: rtl/eeprom_byte_bridge.sv
module eeprom_byte_bridge
  import ebb_pkg::*;
#(
  parameter int          LEN_W      = 10,
  parameter int          NARROW_AW  = 6,
  parameter logic [15:0] ACCESS_KEY = 16'h8139,
  parameter logic [15:0] BIG_SIG    = 16'h8129
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W:0]     req_offset,
  input  logic [LEN_W-1:0]    req_len,
  input  logic [15:0]         req_key,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [BYTE_W-1:0]   wr_data,
  output logic                rd_valid,
  input  logic                rd_ready,
  output logic [BYTE_W-1:0]   rd_data,
  output logic                done,
  output logic                err,
  output logic [15:0]         rsp_key,
  output logic                wm_cmd_valid,
  input  logic                wm_cmd_ready,
  output logic                wm_cmd_write,
  output logic                wm_cmd_wide,
  output logic [ADDR_W-1:0]   wm_cmd_addr,
  output logic [WORD_W-1:0]   wm_cmd_wdata,
  input  logic                wm_rsp_valid,
  input  logic [WORD_W-1:0]   wm_rsp_rdata
);

  localparam int OFF_W = ADDR_W + 1;

  logic              busy;
  logic              req_fire;
  logic              refuse;
  logic              empty;
  logic              wp_go;
  logic              wp_write;
  logic              wp_wide;
  logic [ADDR_W-1:0] wp_addr;
  logic [WORD_W-1:0] wp_wdata;
  logic              wp_done;
  logic [WORD_W-1:0] wp_rdata;

  assign req_ready = !busy;
  assign req_fire  = req_valid && req_ready;

  ebb_gate #(
    .LEN_W      (LEN_W),
    .ACCESS_KEY (ACCESS_KEY)
  ) u_gate (
    .req_write (req_write),
    .req_len   (req_len),
    .req_key   (req_key),
    .refuse    (refuse),
    .empty     (empty)
  );

  ebb_seq #(
    .LEN_W      (LEN_W),
    .OFF_W      (OFF_W),
    .NARROW_AW  (NARROW_AW),
    .ACCESS_KEY (ACCESS_KEY),
    .BIG_SIG    (BIG_SIG)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_fire   (req_fire),
    .req_write  (req_write),
    .req_offset (req_offset),
    .req_len    (req_len),
    .refuse     (refuse),
    .empty      (empty),
    .busy       (busy),
    .wr_valid   (wr_valid),
    .wr_data    (wr_data),
    .wr_ready   (wr_ready),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .rd_ready   (rd_ready),
    .done       (done),
    .err        (err),
    .rsp_key    (rsp_key),
    .wp_go      (wp_go),
    .wp_write   (wp_write),
    .wp_wide    (wp_wide),
    .wp_addr    (wp_addr),
    .wp_wdata   (wp_wdata),
    .wp_done    (wp_done),
    .wp_rdata   (wp_rdata)
  );

  ebb_wordport u_port (
    .clk          (clk),
    .rst_n        (rst_n),
    .go           (wp_go),
    .go_write     (wp_write),
    .go_wide      (wp_wide),
    .go_addr      (wp_addr),
    .go_wdata     (wp_wdata),
    .wp_done      (wp_done),
    .wp_rdata     (wp_rdata),
    .wm_cmd_valid (wm_cmd_valid),
    .wm_cmd_ready (wm_cmd_ready),
    .wm_cmd_write (wm_cmd_write),
    .wm_cmd_wide  (wm_cmd_wide),
    .wm_cmd_addr  (wm_cmd_addr),
    .wm_cmd_wdata (wm_cmd_wdata),
    .wm_rsp_valid (wm_rsp_valid),
    .wm_rsp_rdata (wm_rsp_rdata)
  );

  // R12: idle outputs in reset
  assert_reset_idle_R12: assert property (@(posedge clk)
    !rst_n |=> (!done && !wm_cmd_valid && !rd_valid));

endmodule

// File: tb/test_eeprom_byte_bridge.sv
`timescale 1ns/1ps
module test_eeprom_byte_bridge;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic        req_ready;
  logic [8:0]  req_offset = '0;
  logic [9:0]  req_len = '0;
  logic [15:0] req_key = '0;
  logic        wr_valid = 1'b0, wr_ready;
  logic [7:0]  wr_data = '0;
  logic        rd_valid, rd_ready = 1'b0;
  logic [7:0]  rd_data;
  logic        done, err;
  logic [15:0] rsp_key;
  logic        wm_cmd_valid, wm_cmd_ready = 1'b0, wm_cmd_write, wm_cmd_wide;
  logic [7:0]  wm_cmd_addr;
  logic [15:0] wm_cmd_wdata;
  logic        wm_rsp_valid = 1'b0;
  logic [15:0] wm_rsp_rdata = '0;

  always #10 clk = ~clk;

  eeprom_byte_bridge i_eeprom_byte_bridge (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_offset(req_offset), .req_len(req_len), .req_key(req_key),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .done(done), .err(err), .rsp_key(rsp_key),
    .wm_cmd_valid(wm_cmd_valid), .wm_cmd_ready(wm_cmd_ready),
    .wm_cmd_write(wm_cmd_write), .wm_cmd_wide(wm_cmd_wide),
    .wm_cmd_addr(wm_cmd_addr), .wm_cmd_wdata(wm_cmd_wdata),
    .wm_rsp_valid(wm_rsp_valid), .wm_rsp_rdata(wm_rsp_rdata)
  );

  logic [15:0] mem  [256];
  logic [15:0] refm [256];
  logic [25:0] exp_cmd[$];
  logic [7:0]  exp_rd[$];
  logic [7:0]  wr_q[$];
  logic [7:0]  stage[$];
  int          checks = 0, fails = 0;
  int          fires = 0;
  bit          done_flag = 0, first_cmd = 0;
  logic        got_err;
  logic [15:0] got_key;
  logic        exp_err;
  logic [15:0] exp_key;
  string       wtag = "R5";

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // model of the word master and cycle monitor, acting mid-cycle
  initial begin
    int          cyc = 0, cnt = 0;
    logic [15:0] pend = '0;
    bit          prev_stall = 0;
    logic [25:0] prev_fields = '0;
    forever begin
      @(negedge clk); #1;
      cyc++;
      if (rst_n) begin
        if (prev_stall)  // R11
          chk(wm_cmd_valid && {wm_cmd_write, wm_cmd_wide, wm_cmd_addr, wm_cmd_wdata} == prev_fields,
              "R11 held command", {wm_cmd_write, wm_cmd_wide, wm_cmd_addr, wm_cmd_wdata}, prev_fields);
        wm_rsp_valid = 1'b0;
        if (cnt > 0) begin
          cnt--;
          if (cnt == 0) begin wm_rsp_valid = 1'b1; wm_rsp_rdata = pend; end
        end
        wm_cmd_ready = (cyc % 4) != 2;
        if (wm_cmd_valid && wm_cmd_ready) begin
          logic [25:0] got;
          got = {wm_cmd_write, wm_cmd_wide, wm_cmd_addr, wm_cmd_write ? wm_cmd_wdata : 16'h0};
          if (exp_cmd.size() == 0) chk(0, "R7 unexpected word command", got, 0);
          else begin
            logic [25:0] e;
            e = exp_cmd.pop_front();
            chk(got == e, first_cmd ? "R1 probe command" : (e[25] ? wtag : "R2 word command"), got, e);
          end
          first_cmd = 0;
          if (wm_cmd_write) mem[wm_cmd_addr] = wm_cmd_wdata;
          else pend = mem[wm_cmd_addr];
          cnt = 3;
        end
        prev_stall  = wm_cmd_valid && !wm_cmd_ready;
        prev_fields = {wm_cmd_write, wm_cmd_wide, wm_cmd_addr, wm_cmd_wdata};
        rd_ready = (cyc % 3) != 0;
        if (rd_valid && rd_ready) begin
          if (exp_rd.size() == 0) chk(0, "R3 unexpected byte", rd_data, 0);
          else begin
            logic [7:0] eb;
            eb = exp_rd.pop_front();
            chk(rd_data == eb, "R3 read byte order", rd_data, eb);
          end
        end
        wr_valid = wr_q.size() > 0;
        wr_data  = (wr_q.size() > 0) ? wr_q[0] : 8'h00;
        if (wr_valid && wr_ready) void'(wr_q.pop_front());
        if (req_valid && req_ready) fires++;
        if (done) begin done_flag = 1; got_err = err; got_key = rsp_key; end
      end
    end
  end

  // expectation builder from the requirements
  task automatic plan(input bit w, input int off, input int len, input logic [15:0] key);
    bit big;
    int o, r, idx;
    logic [7:0] a, b0, b1;
    logic [15:0] nw;
    exp_err = 0;
    exp_key = w ? 16'h0000 : 16'h8139;
    if (w && key != 16'h8139) begin exp_err = 1; exp_key = 16'h0000; return; end
    if (len == 0) return;
    exp_cmd.push_back({1'b0, 1'b1, 8'h00, 16'h0});
    big = (refm[0] == 16'h8129);
    o = off; r = len;
    while (r > 0) begin
      idx = o / 2;
      a = big ? 8'(idx % 256) : 8'(idx % 64);
      if (!w) begin
        exp_cmd.push_back({1'b0, big, a, 16'h0});
        if (o % 2 == 1) begin exp_rd.push_back(refm[a][15:8]); o++; r--; end
        else if (r >= 2) begin
          exp_rd.push_back(refm[a][7:0]); exp_rd.push_back(refm[a][15:8]); o += 2; r -= 2;
        end else begin exp_rd.push_back(refm[a][7:0]); o++; r--; end
      end else if (o % 2 == 1) begin
        b0 = stage.pop_front(); wr_q.push_back(b0);
        nw = {b0, refm[a][7:0]};
        exp_cmd.push_back({1'b0, big, a, 16'h0}); exp_cmd.push_back({1'b1, big, a, nw});
        refm[a] = nw; o++; r--;
      end else if (r >= 2) begin
        b0 = stage.pop_front(); b1 = stage.pop_front();
        wr_q.push_back(b0); wr_q.push_back(b1);
        nw = {b1, b0};
        exp_cmd.push_back({1'b1, big, a, nw});
        refm[a] = nw; o += 2; r -= 2;
      end else begin
        b0 = stage.pop_front(); wr_q.push_back(b0);
        nw = {refm[a][15:8], b0};
        exp_cmd.push_back({1'b0, big, a, 16'h0}); exp_cmd.push_back({1'b1, big, a, nw});
        refm[a] = nw; o++; r--;
      end
    end
  endtask

  task automatic start_req(input bit w, input int off, input int len, input logic [15:0] key);
    plan(w, off, len, key);
    done_flag = 0;
    first_cmd = 1;
    @(negedge clk);
    req_valid = 1; req_write = w; req_offset = 9'(off); req_len = 10'(len); req_key = key;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic finish_req(input string tag);
    int diffs = 0;
    while (!done_flag) @(negedge clk);
    @(negedge clk);
    chk(got_err == exp_err, {tag, " err flag"}, got_err, exp_err);
    chk(got_key == exp_key, "R8 key echo", got_key, exp_key);
    chk(exp_cmd.size() == 0, {tag, " missing word commands"}, exp_cmd.size(), 0);
    chk(exp_rd.size() == 0, "R3 missing read bytes", exp_rd.size(), 0);
    for (int i = 0; i < 256; i++) if (mem[i] !== refm[i]) diffs++;
    chk(diffs == 0, {tag, " memory contents"}, diffs, 0);
    exp_cmd.delete(); exp_rd.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int f0;
    for (int i = 0; i < 256; i++) begin mem[i] = 16'(i * 16'h0101) ^ 16'h5a3c; refm[i] = mem[i]; end
    mem[0] = 16'h8129; refm[0] = 16'h8129;
    repeat (5) @(negedge clk);
    // R12 reset state
    chk(req_ready && !done && !rd_valid && !wr_ready && !wm_cmd_valid, "R12 reset outputs",
        {req_ready, done, rd_valid, wr_ready, wm_cmd_valid}, 5'b10000);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(req_ready && !done && !wm_cmd_valid, "R12 idle after reset", {req_ready, done, wm_cmd_valid}, 3'b100);

    // R1 R2 R3 large device reads
    start_req(0, 0, 4, 16'h0); finish_req("R3");
    start_req(0, 3, 4, 16'h0); finish_req("R3");
    // R5 pair writes
    wtag = "R5 pair write";
    stage = '{8'hA1, 8'hB2, 8'hC3, 8'hD4};
    start_req(1, 10, 4, 16'h8139); finish_req("R5");
    // R4 odd start then pair
    wtag = "R4 odd start write";
    stage = '{8'h11, 8'h22, 8'h33};
    start_req(1, 21, 3, 16'h8139); finish_req("R4");
    // R6 odd start plus trailing low byte
    wtag = "R6 trailing write";
    stage = '{8'h5E, 8'h6F};
    start_req(1, 31, 2, 16'h8139); finish_req("R6");
    start_req(0, 19, 15, 16'h0); finish_req("R3");
    // R7 wrong key: nothing consumed, nothing issued
    wr_q.push_back(8'hEE); wr_q.push_back(8'hFF);
    start_req(1, 40, 2, 16'h8138); finish_req("R7");
    chk(wr_q.size() == 2, "R7 write bytes untouched", wr_q.size(), 2);
    @(negedge clk); wr_q.delete();
    // R9 empty requests
    start_req(0, 7, 0, 16'h0); finish_req("R9");
    start_req(1, 7, 0, 16'h8139); finish_req("R9");
    // R10 request offered while busy is ignored
    f0 = fires;
    start_req(0, 40, 6, 16'h0);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); req_valid = 1; req_write = 1; req_key = 16'h0001; req_len = 10'd2;
    end
    @(negedge clk); req_valid = 0;
    finish_req("R10");
    chk(fires - f0 == 1, "R10 acceptances while busy", fires - f0, 1);
    // R2 small device addressing
    @(negedge clk); mem[0] = 16'h1234; refm[0] = 16'h1234;
    start_req(0, 145, 3, 16'h0); finish_req("R2");
    wtag = "R5 pair write narrow";
    stage = '{8'h9A, 8'hBC};
    start_req(1, 132, 2, 16'h8139); finish_req("R2");
    start_req(0, 4, 2, 16'h0); finish_req("R2");

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule